// File: doc/BRIEF.md
# Synchronous Burst SRAM Array

This block is a clocked SRAM array of the kind that sits behind a burst address counter. Chip enable, address, write data and the write controls are all sampled on the rising clock edge. A new address can be presented on every cycle, so back-to-back accesses cost no idle cycles. The burst counter lives outside the block and presents the address to use on `addr`. Writes either cover the whole word, through the global write control, or only the byte lanes picked by the per-lane selects while the byte-write enable is high.

A static mode input chooses the read path. In flow-through mode the array output goes straight to the pins in the cycle after the read is captured. In pipelined mode the data passes through one more output register first. Output turn-off follows single-cycle deselect: a deselect takes effect one stage sooner than read data does. Output enable and sleep act without the clock. Sleep freezes the command path and keeps the stored contents.

The bidirectional data bus is modelled as a data output `q` plus a drive flag `q_drive`. High impedance is shown by `q_drive` low, with `q` held at zero.

Top module: `sync_burst_sram`

## Requirements
- R1: After synchronous reset `q_drive` is low and `q` is zero until a read has been captured.
- R2: When `glob_wr` is high in a captured cycle, every byte lane at `addr` takes `wdata`, whatever `byte_wr_en` and `lane_sel` hold.
- R3: Without `glob_wr`, a cycle is a write only if `byte_wr_en` is high and at least one `lane_sel` bit is high. Only lanes whose select is high are written: bit 0 covers `wdata[8:0]` and bit 1 covers `wdata[17:9]`. Any other enabled cycle is a read and changes no stored data.
- R4: With `pipe_mode` low (flow-through), a read captured at edge E drives `q` with the addressed word from edge E until edge E+1.
- R5: With `pipe_mode` high (pipelined), a read captured at edge E drives `q` with the addressed word from edge E+1 until edge E+2. Its data is the word stored before any write captured at E+1.
- R6: A deselect (`chip_en` low) captured at edge E turns `q_drive` off from edge E onward, in both modes. This includes a pipelined read captured at E-1.
- R7: Reads on consecutive cycles at different addresses each produce their own word in consecutive cycles, with no idle cycle between them.
- R8: While `out_en` is low, `q_drive` is low and `q` is zero at once, without waiting for a clock edge.
- R9: While `sleep` is high, `q_drive` goes low at once, commands are ignored (no write takes effect), and stored data is retained.
- R10: The first clock edge after `sleep` falls captures a command normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the control pipeline |
| pipe_mode | input | 1 | Static: 1 selects the registered output, 0 selects flow-through |
| chip_en | input | 1 | Command enable; low is a deselect |
| addr | input | ADDR_W | Current address from the external burst counter |
| wdata | input | LANES*LANE_W | Write data |
| glob_wr | input | 1 | Write all lanes |
| byte_wr_en | input | 1 | Enables lane-selected writes |
| lane_sel | input | LANES | Per-lane write selects |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep request |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_drive | output | 1 | High while the data bus is driven |

## Verification
The sharpest overlap is a pipelined read whose data is due out in the same cycle that a deselect is captured. The single-cycle deselect rule has to win, so the word must never appear. The bench provokes this by following a read at once with a deselect in pipelined mode. It expects the bus to stay undriven in the next cycle, while a read followed by an active cycle does show its word. A second overlap, a pipelined read followed at once by a write to the same address, is judged by expecting the pre-write word on `q`.

// File: rtl/sram_pkg.sv
package sram_pkg;

    parameter int LANE_W_DEF = 9;
    parameter int LANES_DEF  = 2;
    parameter int ADDR_W_DEF = 6;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // State of the output side after each edge
    typedef struct packed {
        logic rd_cap;   // a read was captured on the last edge
        logic pipe_drv; // registered drive for pipelined mode
    } out_state_t;

    function automatic op_e classify(input logic active, input logic wr_any);
        if (!active)
            return OP_NONE;
        else if (wr_any)
            return OP_WRITE;
        else
            return OP_READ;
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_pkg::*;
#(
    parameter int LANES = LANES_DEF
) (
    input  logic             chip_en,
    input  logic             sleep,
    input  logic             glob_wr,
    input  logic             byte_wr_en,
    input  logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] lane_we,
    output logic             rd_cmd,
    output logic             active
);

    logic wr_any;
    op_e  op;

    assign active = chip_en & ~sleep;
    assign wr_any = glob_wr | (byte_wr_en & (|lane_sel));
    assign op     = classify(active, wr_any);
    assign rd_cmd = (op == OP_READ);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_we
        assign lane_we[l] = (op == OP_WRITE) & (glob_wr | (byte_wr_en & lane_sel[l]));
    end

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[l])
                bank[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
#(
    parameter int DW = LANES_DEF * LANE_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_mode,
    input  logic          out_en,
    input  logic          sleep,
    input  logic          rd_cmd,
    input  logic          active,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] q,
    output logic          q_drive
);

    out_state_t      st;
    logic [DW-1:0]   pipe_data;
    logic            path_drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.rd_cap   <= rd_cmd;
            // Single-cycle deselect: an inactive cycle cancels the pending word
            st.pipe_drv <= st.rd_cap & active;
        end
    end

    always_ff @(posedge clk) begin
        if (st.rd_cap)
            pipe_data <= arr_rdata;
    end

    assign path_drv = pipe_mode ? st.pipe_drv : st.rd_cap;
    assign q_drive  = out_en & ~sleep & path_drv;
    assign q        = q_drive ? (pipe_mode ? pipe_data : arr_rdata) : '0;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pipe_mode,
    input  logic                    chip_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    glob_wr,
    input  logic                    byte_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic                    out_en,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_drive
);

    localparam int DW = LANES * LANE_W;

    logic [LANES-1:0]  lane_we;
    logic              rd_cmd;
    logic              active;
    logic [ADDR_W-1:0] raddr_q;
    logic [DW-1:0]     arr_rdata;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .chip_en    (chip_en),
        .sleep      (sleep),
        .glob_wr    (glob_wr),
        .byte_wr_en (byte_wr_en),
        .lane_sel   (lane_sel),
        .lane_we    (lane_we),
        .rd_cmd     (rd_cmd),
        .active     (active)
    );

    always_ff @(posedge clk) begin
        if (rst)
            raddr_q <= '0;
        else if (rd_cmd)
            raddr_q <= addr;
    end

    sram_array #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (addr),
        .wdata   (wdata),
        .raddr   (raddr_q),
        .rdata   (arr_rdata)
    );

    sram_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .out_en    (out_en),
        .sleep     (sleep),
        .rd_cmd    (rd_cmd),
        .active    (active),
        .arr_rdata (arr_rdata),
        .q         (q),
        .q_drive   (q_drive)
    );

endmodule

// File: rtl/sram_prop_chk.sv
module sram_prop_chk #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pipe_mode,
    input logic                    chip_en,
    input logic                    glob_wr,
    input logic                    byte_wr_en,
    input logic [LANES-1:0]        lane_sel,
    input logic                    out_en,
    input logic                    sleep,
    input logic [LANES*LANE_W-1:0] q,
    input logic                    q_drive
);

    logic rd_seen;
    logic live;

    assign rd_seen = chip_en & ~sleep & ~rst & ~glob_wr & ~(byte_wr_en & (|lane_sel));
    assign live    = out_en & ~sleep;

    // R4: flow-through read shows on the bus after its capture edge
    p_flow_drive_r4: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && live && $past(rd_seen)) |-> q_drive);

    // R5: pipelined read shows one edge later when the next cycle is active
    p_pipe_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && live && $past(rd_seen, 2) && $past(chip_en && !sleep && !rst)) |-> q_drive);

    // R6: a captured deselect turns the bus off at once
    p_scd_off_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!chip_en && !rst) |-> !q_drive);

    // R8: output enable low releases the bus
    p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!q_drive && q == '0));

    // R9: sleep releases the bus
    p_sleep_off_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !q_drive);

endmodule

bind sync_burst_sram sram_prop_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pipe_mode  (pipe_mode),
    .chip_en    (chip_en),
    .glob_wr    (glob_wr),
    .byte_wr_en (byte_wr_en),
    .lane_sel   (lane_sel),
    .out_en     (out_en),
    .sleep      (sleep),
    .q          (q),
    .q_drive    (q_drive)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/100ps
module test_sync_burst_sram;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int ADDR_W = 6;
    localparam int DW     = LANE_W * LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pipe_mode = 1'b0;
    logic              chip_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic              glob_wr = 1'b0;
    logic              byte_wr_en = 1'b0;
    logic [LANES-1:0]  lane_sel = '0;
    logic              out_en = 1'b1;
    logic              sleep = 1'b0;
    logic [DW-1:0]     q;
    logic              q_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .chip_en(chip_en), .addr(addr),
        .wdata(wdata), .glob_wr(glob_wr), .byte_wr_en(byte_wr_en), .lane_sel(lane_sel),
        .out_en(out_en), .sleep(sleep), .q(q), .q_drive(q_drive)
    );

    typedef struct {
        logic          drv;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state
    logic [DW-1:0]     mdl [DEPTH];
    logic              m_rd1;
    logic              m_pdrv;
    logic [DW-1:0]     m_pdata;
    logic [ADDR_W-1:0] m_raddr;

    task automatic check(input string tag, input logic drv, input logic [DW-1:0] data);
        n_checks++;
        if (q_drive !== drv || q !== data) begin
            n_fail++;
            $display("FAIL %s: drive=%0b q=%h expected drive=%0b q=%h", tag, q_drive, q, drv, data);
        end
    endtask

    task automatic model_reset();
        m_rd1 = 1'b0; m_pdrv = 1'b0; m_pdata = '0; m_raddr = '0;
    endtask

    // Drive one command, push the expected bus state after the next edge
    task automatic cyc(input logic ce, input logic gw, input logic bwe, input logic [LANES-1:0] sel,
                       input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, input logic slp,
                       input string tag);
        logic act, wr_any, rd_now, n_pdrv, drv;
        logic [DW-1:0] n_pdata, dat;
        exp_t e;
        @(negedge clk);
        chip_en = ce; glob_wr = gw; byte_wr_en = bwe; lane_sel = sel; addr = a; wdata = d; sleep = slp;
        act    = ce & ~slp;
        wr_any = gw | (bwe & (|sel));
        rd_now = act & ~wr_any;
        n_pdrv = m_rd1 & act;
        n_pdata = m_rd1 ? mdl[m_raddr] : m_pdata;
        if (act && wr_any)
            for (int l = 0; l < LANES; l++)
                if (gw || sel[l]) mdl[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        m_pdrv = n_pdrv; m_pdata = n_pdata;
        m_rd1 = rd_now;
        if (rd_now) m_raddr = a;
        drv = out_en & ~slp & (pipe_mode ? m_pdrv : m_rd1);
        dat = drv ? (pipe_mode ? m_pdata : mdl[m_raddr]) : '0;
        e.drv = drv; e.data = dat; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, e.drv, e.data);
            end
        end
    end

    task automatic do_reset(input logic pm);
        @(negedge clk);
        rst = 1'b1; pipe_mode = pm; chip_en = 1'b0; sleep = 1'b0; out_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #0.5 check("R1 reset idle", 1'b0, '0);
    endtask

    localparam logic [DW-1:0] W_A = 18'h2A5A5;
    localparam logic [DW-1:0] W_B = 18'h1C3C3;
    localparam logic [DW-1:0] W_C = 18'h0F0F1;
    localparam logic [DW-1:0] W_D = 18'h3FFFF;

    initial begin
        model_reset();
        // ---------- flow-through ----------
        do_reset(1'b0);
        cyc(1, 1, 0, 2'b00, 6'd5,  W_A, 0, "R2 global write");
        cyc(1, 1, 1, 2'b01, 6'd9,  W_B, 0, "R2 global write ignores selects");
        cyc(1, 1, 0, 2'b00, 6'd20, W_C, 0, "R2 global write");
        cyc(1, 0, 0, 2'b00, 6'd5,  '0,  0, "R4 flow read");
        cyc(1, 0, 0, 2'b00, 6'd9,  '0,  0, "R7 flow back-to-back");
        cyc(1, 0, 0, 2'b00, 6'd20, '0,  0, "R7 flow back-to-back");
        cyc(1, 0, 1, 2'b01, 6'd5,  W_D, 0, "R3 lane 0 write");
        cyc(1, 0, 1, 2'b10, 6'd9,  W_D, 0, "R3 lane 1 write");
        cyc(1, 0, 0, 2'b11, 6'd20, W_D, 0, "R3 selects without enable is read");
        cyc(1, 0, 1, 2'b00, 6'd5,  W_D, 0, "R3 enable without selects is read");
        cyc(1, 0, 0, 2'b00, 6'd9,  '0,  0, "R3 lane 1 readback");
        cyc(1, 0, 0, 2'b00, 6'd20, '0,  0, "R3 unchanged word");
        cyc(0, 0, 0, 2'b00, 6'd20, '0,  0, "R6 flow deselect off");
        cyc(1, 0, 0, 2'b00, 6'd20, '0,  0, "R4 flow read");
        // R8: drop output enable mid-cycle
        @(posedge clk); #2;
        out_en = 1'b0; #0.2;
        check("R8 output enable low releases", 1'b0, '0);
        @(negedge clk); out_en = 1'b1;
        cyc(1, 0, 0, 2'b00, 6'd5,  '0,  0, "R4 flow read");
        // R9: async sleep, writes ignored while asleep
        @(posedge clk); #2;
        sleep = 1'b1; #0.2;
        check("R9 sleep releases at once", 1'b0, '0);
        cyc(1, 1, 0, 2'b00, 6'd5, W_C, 1, "R9 write while asleep");
        cyc(1, 0, 0, 2'b00, 6'd5, '0,  1, "R9 read while asleep");
        cyc(1, 0, 0, 2'b00, 6'd5, '0,  0, "R10 first edge after sleep");
        cyc(0, 0, 0, 2'b00, 6'd5, '0,  0, "R6 flow deselect off");
        // ---------- pipelined ----------
        do_reset(1'b1);
        cyc(1, 1, 0, 2'b00, 6'd40, W_A, 0, "R2 pipe global write");
        cyc(1, 1, 0, 2'b00, 6'd41, W_B, 0, "R2 pipe global write");
        cyc(1, 0, 0, 2'b00, 6'd40, '0,  0, "R5 pipe read issue");
        cyc(1, 0, 0, 2'b00, 6'd41, '0,  0, "R5 pipe first word");
        cyc(1, 0, 0, 2'b00, 6'd5,  '0,  0, "R7 pipe back-to-back");
        cyc(1, 1, 0, 2'b00, 6'd5,  W_C, 0, "R5 pipe read then write same address");
        cyc(1, 0, 0, 2'b00, 6'd5,  '0,  0, "R5 pipe read new word");
        cyc(1, 0, 0, 2'b00, 6'd40, '0,  0, "R5 pipe new word out");
        cyc(0, 0, 0, 2'b00, 6'd40, '0,  0, "R6 pipe deselect cancels pending read");
        cyc(0, 0, 0, 2'b00, 6'd40, '0,  0, "R6 pipe stays off");
        cyc(1, 0, 0, 2'b00, 6'd41, '0,  0, "R5 pipe read issue");
        cyc(1, 0, 0, 2'b00, 6'd40, '0,  1, "R9 pipe sleep cancels");
        cyc(1, 0, 0, 2'b00, 6'd41, '0,  0, "R10 pipe resume");
        cyc(1, 0, 0, 2'b00, 6'd40, '0,  0, "R10 pipe word after resume");
        cyc(0, 0, 0, 2'b00, 6'd40, '0,  0, "R6 pipe deselect");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule